// File: doc/BRIEF.md
# Power Button and Watchdog Event Filter

This block sits in front of a system power sequencer and turns raw, slow-moving board inputs into clean single-cycle requests. The power button is synchronised and debounced. Once a press is accepted it can ask the sequencer to leave the off state. It also starts a long hold timer. If the button is still held when that timer runs out, the block asks for a forced shutdown. A lid that opens while the system is off also asks to leave the off state.

The application processor's watchdog line is treated with more suspicion. A normal shutdown also toggles that line, so an active watchdog edge only opens a re-check window. A reset request is issued at the end of the window, and only if the processor is then neither held in reset nor suspended. Watchdog edges that arrive while the sequencer is already resetting or shutting the processor down are discarded. A new edge inside an open window restarts the window instead of adding a second request. All time is counted in ticks of a shared 1 ms strobe, so the hold time, debounce time and re-check delay are parameters in milliseconds.

Top module: `pwr_evt_filter`

## Requirements
- R1: A button level change is accepted only after it has been stable for DEBOUNCE_MS ticks (default 16). A press that is accepted while `sys_off` is high produces one `exit_off_req` pulse. A press shorter than the debounce time produces nothing.
- R2: Every accepted press starts the hold timer, whatever the power state. After HOLD_MS ticks (default 8000) of continued hold, `force_off_req` pulses if `sys_off` is low at that moment.
- R3: An accepted release before the hold timer expires cancels the pending forced shutdown.
- R4: If the hold timer expires while `sys_off` is high, no `force_off_req` is produced.
- R5: A one-cycle pulse on `enter_s3s5` cancels a running hold timer, and the still-held button then produces no forced shutdown.
- R6: A rising edge on `lid_open` (1 = open) while `sys_off` is high produces one `exit_off_req` pulse within 1 ms. Opening the lid while `sys_off` is low has no effect.
- R7: A watchdog event is a falling edge of `wdt_n` (active low by default). An event that occurs while `resetting` or `shutting_down` is high is ignored and produces no request.
- R8: An accepted watchdog event opens a window of WDT_DELAY_MS ticks (default 150). When the window closes, `wdt_rst_req` pulses only if `ap_in_rst` and `ap_suspend` are both low in that cycle.
- R9: An accepted watchdog event that arrives while a window is open restarts the window. Only one `wdt_rst_req` results, timed from the later event.
- R10: All three request outputs are low during reset, and each request is exactly one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle strobe, once per millisecond |
| btn_raw | input | 1 | Raw power button level, 1 = pressed (asynchronous) |
| lid_open | input | 1 | Lid switch level, 1 = open (asynchronous) |
| wdt_n | input | 1 | Processor watchdog reset line (asynchronous) |
| ap_in_rst | input | 1 | Processor is held in reset |
| ap_suspend | input | 1 | Processor has signalled suspend |
| resetting | input | 1 | Sequencer is running a processor reset |
| shutting_down | input | 1 | Sequencer is running a forced shutdown |
| sys_off | input | 1 | System is in an off state |
| enter_s3s5 | input | 1 | Pulse when the sequencer begins the suspend-to-off transition |
| exit_off_req | output | 1 | Request to leave the off state |
| force_off_req | output | 1 | Request for a forced shutdown after a long hold |
| wdt_rst_req | output | 1 | Qualified watchdog reset request |

## Verification
The bound checker watches every cycle for the conditions that qualify each request. A wake request must follow a cycle with the system off. A forced shutdown must follow a cycle with the system on. A watchdog request must follow a cycle with the processor neither in reset nor suspended. The forced-shutdown and watchdog requests must also be single pulses. Timing and cancellation cannot be seen cycle by cycle: the debounce delay, the hold length, cancellation by release or by the off transition, edge suppression during resets and window restart. The bench scenarios cover these. Each scenario predicts when every request should appear and shows that cancelled or suppressed requests never appear.

// File: rtl/pef_pkg.sv
package pef_pkg;

   // Request bundle produced by the filter, registered at the top level.
   typedef struct packed {
      logic exit_off;
      logic force_off;
      logic wdt_rst;
   } pef_req_t;

   // Counter width able to hold the value n (at least one bit).
   function automatic int unsigned cnt_w(input int unsigned n);
      int unsigned w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("pef_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= RST_VAL;
            else        ff_q <= d;
         end
         assign q = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pef_debounce.sv
module pef_debounce #(
   parameter int unsigned STABLE_MS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   output logic rise,
   output logic fall
);

   localparam int unsigned CW   = pef_pkg::cnt_w(STABLE_MS);
   localparam logic [CW-1:0] LAST = CW'(STABLE_MS - 1);

   generate
      if (STABLE_MS < 1) begin : g_bad_stable
         $error("pef_debounce: STABLE_MS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q;
   logic          lvl_q;
   logic          differs;
   logic          flip;

   assign differs = (din != lvl_q);
   assign flip    = differs && tick && (run_q == LAST);
   assign rise    = flip &&  din;
   assign fall    = flip && !din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (!differs) begin
         run_q <= '0;
      end else if (flip) begin
         run_q <= '0;
         lvl_q <= din;
      end else if (tick) begin
         run_q <= run_q + 1'b1;
      end
   end

endmodule

// File: rtl/pef_ms_timer.sv
module pef_ms_timer #(
   parameter int unsigned LIMIT = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic cancel,
   output logic expire
);

   localparam int unsigned    CW   = pef_pkg::cnt_w(LIMIT);
   localparam logic [CW-1:0]  LOAD = CW'(LIMIT);
   localparam logic [CW-1:0]  ONE  = CW'(1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pef_ms_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;
   logic          run_q;

   // start takes priority over cancel and over an expiry in the same cycle
   assign expire = run_q && tick && (left_q == ONE) && !start && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         run_q  <= 1'b0;
      end else if (start) begin
         left_q <= LOAD;
         run_q  <= 1'b1;
      end else if (cancel) begin
         run_q  <= 1'b0;
      end else if (run_q && tick) begin
         if (left_q == ONE) run_q  <= 1'b0;
         else               left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/pwr_evt_filter.sv
module pwr_evt_filter #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DEBOUNCE_MS    = 16,
   parameter int unsigned HOLD_MS        = 8000,
   parameter int unsigned WDT_DELAY_MS   = 150,
   parameter bit          WDT_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1ms,
   input  logic btn_raw,
   input  logic lid_open,
   input  logic wdt_n,
   input  logic ap_in_rst,
   input  logic ap_suspend,
   input  logic resetting,
   input  logic shutting_down,
   input  logic sys_off,
   input  logic enter_s3s5,
   output logic exit_off_req,
   output logic force_off_req,
   output logic wdt_rst_req
);

   import pef_pkg::*;

   localparam logic WDT_IDLE = WDT_ACTIVE_LOW ? 1'b1 : 1'b0;

   generate
      if (HOLD_MS <= DEBOUNCE_MS) begin : g_bad_hold
         $error("pwr_evt_filter: HOLD_MS must exceed DEBOUNCE_MS");
      end
      if (WDT_DELAY_MS < 1) begin : g_bad_wdt
         $error("pwr_evt_filter: WDT_DELAY_MS must be at least 1");
      end
   endgenerate

   // ---------------- input synchronisation ----------------
   logic btn_s, lid_s, wdt_s;

   pef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_btn (
      .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn_s));
   pef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lid (
      .clk(clk), .rst_n(rst_n), .d(lid_open), .q(lid_s));
   pef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(WDT_IDLE)) u_sync_wdt (
      .clk(clk), .rst_n(rst_n), .d(wdt_n), .q(wdt_s));

   // ---------------- button ----------------
   logic btn_press, btn_release;

   pef_debounce #(.STABLE_MS(DEBOUNCE_MS)) u_btn_db (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .din(btn_s),
      .rise(btn_press), .fall(btn_release));

   logic hold_done;

   pef_ms_timer #(.LIMIT(HOLD_MS)) u_hold_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms),
      .start(btn_press), .cancel(btn_release | enter_s3s5),
      .expire(hold_done));

   // ---------------- lid ----------------
   logic lid_prev_q, lid_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lid_prev_q <= 1'b0;
      else        lid_prev_q <= lid_s;
   end
   assign lid_rise = lid_s & ~lid_prev_q;

   // ---------------- watchdog ----------------
   logic wdt_prev_q, wdt_evt, wdt_take, wdt_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdt_prev_q <= WDT_IDLE;
      else        wdt_prev_q <= wdt_s;
   end

   generate
      if (WDT_ACTIVE_LOW) begin : g_wdt_low
         assign wdt_evt = wdt_prev_q & ~wdt_s;
      end else begin : g_wdt_high
         assign wdt_evt = ~wdt_prev_q & wdt_s;
      end
   endgenerate

   assign wdt_take = wdt_evt & ~resetting & ~shutting_down;

   pef_ms_timer #(.LIMIT(WDT_DELAY_MS)) u_wdt_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms),
      .start(wdt_take), .cancel(1'b0), .expire(wdt_done));

   // ---------------- qualified, registered requests ----------------
   pef_req_t req_d, req_q;

   always_comb begin
      req_d.exit_off  = sys_off & (btn_press | lid_rise);
      req_d.force_off = hold_done & ~sys_off;
      req_d.wdt_rst   = wdt_done & ~ap_in_rst & ~ap_suspend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end

   assign exit_off_req  = req_q.exit_off;
   assign force_off_req = req_q.force_off;
   assign wdt_rst_req   = req_q.wdt_rst;

endmodule

// File: rtl/pef_filter_chk.sv
module pef_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic ap_in_rst,
   input logic ap_suspend,
   input logic sys_off,
   input logic exit_off_req,
   input logic force_off_req,
   input logic wdt_rst_req
);

   AST_EXIT_ONLY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      exit_off_req |-> $past(sys_off));                               // R1

   AST_FORCE_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |-> !$past(sys_off));                             // R4

   AST_WDT_ONLY_FULLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |-> (!$past(ap_in_rst) && !$past(ap_suspend)));    // R8

   AST_FORCE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |=> !force_off_req);                              // R10

   AST_WDT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> !wdt_rst_req);                                  // R9

endmodule

bind pwr_evt_filter pef_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ap_in_rst(ap_in_rst), .ap_suspend(ap_suspend),
   .sys_off(sys_off), .exit_off_req(exit_off_req),
   .force_off_req(force_off_req), .wdt_rst_req(wdt_rst_req));

// File: tb/pwr_evt_filter_tb.sv
module pwr_evt_filter_tb;

   localparam int DEB  = 16;
   localparam int HOLD = 200;
   localparam int WDLY = 150;

   localparam int K_EXIT  = 0;
   localparam int K_FORCE = 1;
   localparam int K_WDT   = 2;

   typedef struct {
      int    kind;
      int    lo;
      int    hi;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1ms = 1'b0;
   logic btn_raw = 1'b0, lid_open = 1'b0, wdt_n = 1'b1;
   logic ap_in_rst = 1'b0, ap_suspend = 1'b0;
   logic resetting = 1'b0, shutting_down = 1'b0, sys_off = 1'b0, enter_s3s5 = 1'b0;
   logic exit_off_req, force_off_req, wdt_rst_req;

   int    n_checks = 0;
   int    n_errors = 0;
   int    ms_now   = 0;
   int    div      = 0;
   bit    done     = 1'b0;
   string cur_tag  = "R10";
   exp_t  sb[$];

   always #2 clk = ~clk;   // 250 MHz

   pwr_evt_filter #(
      .SYNC_STAGES(2), .DEBOUNCE_MS(DEB), .HOLD_MS(HOLD),
      .WDT_DELAY_MS(WDLY), .WDT_ACTIVE_LOW(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .btn_raw(btn_raw),
      .lid_open(lid_open), .wdt_n(wdt_n), .ap_in_rst(ap_in_rst),
      .ap_suspend(ap_suspend), .resetting(resetting),
      .shutting_down(shutting_down), .sys_off(sys_off),
      .enter_s3s5(enter_s3s5), .exit_off_req(exit_off_req),
      .force_off_req(force_off_req), .wdt_rst_req(wdt_rst_req));

   // 1 ms strobe: one cycle in four
   always @(negedge clk) begin
      div      <= (div + 1) % 4;
      tick_1ms <= (div == 3);
      if (div == 3) ms_now <= ms_now + 1;
   end

   task automatic wait_ms(input int n);
      repeat (n * 4) @(negedge clk);
   endtask

   task automatic expect_req(input int kind, input int lo, input int hi, input string tag);
      exp_t e;
      e.kind = kind; e.lo = lo; e.hi = hi; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic check_idle(input string tag);
      n_checks++;
      if (sb.size() != 0) begin
         n_errors++;
         $display("FAIL %s missing request: got none, expected %0d pending (kind %0d)",
                  tag, sb.size(), sb[0].kind);
         sb.delete();
      end
   endtask

   task automatic compare(input int kind);
      exp_t e;
      n_checks++;
      if (sb.size() == 0) begin
         n_errors++;
         $display("FAIL %s unexpected request: got kind %0d at ms %0d, expected none",
                  cur_tag, kind, ms_now);
      end else begin
         e = sb.pop_front();
         if (e.kind != kind || ms_now < e.lo || ms_now > e.hi) begin
            n_errors++;
            $display("FAIL %s got kind %0d at ms %0d, expected kind %0d in ms %0d..%0d",
                     e.tag, kind, ms_now, e.kind, e.lo, e.hi);
         end
      end
   endtask

   // monitor: each high cycle of a request is one item (R10: a longer pulse fails)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exit_off_req)  compare(K_EXIT);
         if (force_off_req) compare(K_FORCE);
         if (wdt_rst_req)   compare(K_WDT);
      end
   end

   task automatic wdt_edge();
      wdt_n = 1'b0;
      wait_ms(2);
      wdt_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL %s watchdog expired: got hang, expected completion", cur_tag);
         finish_run();
      end
   end

   initial begin
      int p;
      int w;
      repeat (10) @(negedge clk);
      // R10: reset state
      n_checks++;
      if ({exit_off_req, force_off_req, wdt_rst_req} != 3'b000) begin
         n_errors++;
         $display("FAIL R10 reset outputs got %b expected 000",
                  {exit_off_req, force_off_req, wdt_rst_req});
      end
      rst_n = 1'b1;
      wait_ms(5);

      // R1: short bounce ignored
      cur_tag = "R1"; sys_off = 1'b1;
      btn_raw = 1'b1; wait_ms(10); btn_raw = 1'b0; wait_ms(40);
      check_idle("R1");

      // R1 + R4: press while off -> wake request, hold expiry gives nothing
      cur_tag = "R4"; p = ms_now;
      expect_req(K_EXIT, p + DEB - 1, p + DEB + 3, "R1");
      btn_raw = 1'b1; wait_ms(HOLD + 60); btn_raw = 1'b0; wait_ms(40);
      check_idle("R4");

      // R2: long hold while on -> forced shutdown
      cur_tag = "R2"; sys_off = 1'b0; p = ms_now;
      expect_req(K_FORCE, p + DEB + HOLD - 2, p + DEB + HOLD + 3, "R2");
      btn_raw = 1'b1; wait_ms(HOLD + 60); btn_raw = 1'b0; wait_ms(40);
      check_idle("R2");

      // R3: early release cancels
      cur_tag = "R3";
      btn_raw = 1'b1; wait_ms(100); btn_raw = 1'b0; wait_ms(HOLD);
      check_idle("R3");

      // R5: off transition cancels a running hold
      cur_tag = "R5";
      btn_raw = 1'b1; wait_ms(100);
      enter_s3s5 = 1'b1; @(negedge clk); enter_s3s5 = 1'b0;
      wait_ms(HOLD); btn_raw = 1'b0; wait_ms(40);
      check_idle("R5");

      // R6: lid open while on ignored, while off wakes
      cur_tag = "R6";
      lid_open = 1'b1; wait_ms(10); lid_open = 1'b0; wait_ms(10);
      check_idle("R6");
      sys_off = 1'b1; p = ms_now;
      expect_req(K_EXIT, p, p + 1, "R6");
      lid_open = 1'b1; wait_ms(10); lid_open = 1'b0; wait_ms(10);
      check_idle("R6");
      sys_off = 1'b0;

      // R7: edges ignored during reset or shutdown
      cur_tag = "R7";
      resetting = 1'b1; wdt_edge(); wait_ms(WDLY + 50); resetting = 1'b0;
      check_idle("R7");
      shutting_down = 1'b1; wdt_edge(); wait_ms(WDLY + 50); shutting_down = 1'b0;
      check_idle("R7");

      // R8: delayed re-check, qualified by processor state
      cur_tag = "R8"; w = ms_now;
      expect_req(K_WDT, w + WDLY - 1, w + WDLY + 2, "R8");
      wdt_edge(); wait_ms(WDLY + 50);
      check_idle("R8");
      ap_suspend = 1'b1; wdt_edge(); wait_ms(WDLY + 50); ap_suspend = 1'b0;
      check_idle("R8");
      ap_in_rst = 1'b1; wdt_edge(); wait_ms(WDLY + 50); ap_in_rst = 1'b0;
      check_idle("R8");

      // R9: second edge inside the window restarts it, one request
      cur_tag = "R9";
      wdt_edge(); wait_ms(98);
      w = ms_now;
      expect_req(K_WDT, w + WDLY - 1, w + WDLY + 2, "R9");
      wdt_edge(); wait_ms(WDLY + 50);
      check_idle("R9");

      finish_run();
   end

endmodule